// File: doc/BRIEF.md
# Bus-Matching Mailbox Register

This block is a single-entry message slot that lets the read side of a dual-port buffer (port B) hand one 36-bit word back to the write side (port A) without passing through the buffer's storage. Port B deposits a message by raising its chip select, enable, write-direction and mailbox-select inputs together in one clock cycle. Port A collects the message by raising its own chip select, enable, read-direction and mailbox-select inputs together. The message then appears on port A's registered data output.

Port B has a programmable bus width: long word (36 bits), word (18 bits) or byte (9 bits). Only the lanes that belong to the selected width are captured. Lanes above that width are forced to zero in the stored word. A software model that treats those upper bits as undefined therefore stays correct.

The slot uses one flag, `mbx_full`, toward port A. It acts as the back-pressure signal for port B. While it is high, port B writes are dropped, not queued, so a sender must wait for the flag to fall before sending again. Reading the slot does not erase it: the stored word remains until the next accepted write. Both ports share one clock in this model.

Top module: `mbx_bridge`

## Requirements
- R1: After reset, `mbx_full` is 0, `a_data` is 0 and the stored word is 0. A qualified port A read straight after reset returns 0.
- R2: A write is qualified when `b_sel`, `b_en`, `b_wr` and `b_mbx` are all 1 in the same cycle. If any of them is 0, nothing is stored and `mbx_full` stays 0.
- R3: With `b_size` = 2'b00 (long word) or 2'b11 (treated the same way), an accepted write stores all bits 35:0 of `b_data`.
- R4: With `b_size` = 2'b01 (word), an accepted write stores bits 17:0 of `b_data`. Bits 35:18 of the stored word become 0.
- R5: With `b_size` = 2'b10 (byte), an accepted write stores bits 8:0 of `b_data`. Bits 35:9 of the stored word become 0.
- R6: `mbx_full` goes to 1 on the rising clock edge that ends the cycle of an accepted write.
- R7: A qualified write that arrives while `mbx_full` is 1 is ignored. The stored word and the flag do not change.
- R8: A read is qualified when `a_sel`, `a_en`, `a_rd` and `a_mbx` are all 1 in the same cycle. A qualified read loads the stored word into the `a_data` register at the edge that ends the cycle, and clears `mbx_full` at that same edge.
- R9: The stored word survives a read. A second qualified read with no write in between returns the same value.
- R10: If any of the four port A qualifiers is 0, `a_data` and `mbx_full` are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| b_sel | input | 1 | Port B chip select, active high |
| b_en | input | 1 | Port B enable |
| b_wr | input | 1 | Port B direction, 1 = write |
| b_mbx | input | 1 | Port B mailbox select |
| b_size | input | 2 | Port B bus width: 00 long, 01 word, 10 byte, 11 long |
| b_data | input | 36 | Port B message input |
| a_sel | input | 1 | Port A chip select, active high |
| a_en | input | 1 | Port A enable |
| a_rd | input | 1 | Port A direction, 1 = read |
| a_mbx | input | 1 | Port A mailbox select |
| a_data | output | 36 | Port A registered message output |
| mbx_full | output | 1 | An unread message is waiting; port B writes are dropped while it is high |

## Verification
The assertions assume that `b_size` is stable during the cycle of a qualified write. They also assume that reset is held for at least one clock edge before any qualifier rises. The stimulus changes inputs only on the falling edge and holds each bus-size code for the whole write cycle. Write-while-full and read-while-empty are driven on purpose, so the drop and hold properties are exercised and not merely vacuous.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    BS_LONG = 2'b00,
    BS_WORD = 2'b01,
    BS_BYTE = 2'b10,
    BS_RSVD = 2'b11
  } bus_size_e;
endpackage

// File: rtl/mbx_lane_capture.sv
module mbx_lane_capture
  import mbx_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int WORD_W = 18,
  parameter int BYTE_W = 9
) (
  input  bus_size_e           size,
  input  logic [DATA_W-1:0]   din,
  output logic [DATA_W-1:0]   cap
);
  logic [DATA_W-1:0] keep;

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    if (i < BYTE_W) begin : g_byte
      assign keep[i] = 1'b1;
    end else if (i < WORD_W) begin : g_word
      assign keep[i] = (size != BS_BYTE);
    end else begin : g_long
      assign keep[i] = (size == BS_LONG) || (size == BS_RSVD);
    end
  end

  assign cap = din & keep;
endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] wr_word,
  output logic [DATA_W-1:0] word_q,
  output logic              full_q,
  output logic              wr_acc
);
  assign wr_acc = wr_req && !full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (wr_acc) word_q <= wr_word;
      if (wr_acc)      full_q <= 1'b1;
      else if (rd_req) full_q <= 1'b0;
    end
  end

  a_r6_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !full_q) |=> full_q);
  a_r7_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !rd_req) |=> (full_q && $stable(word_q)));
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && rd_req) |=> !full_q);
  a_r9_word_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_req) |=> $stable(word_q));
endmodule

// File: rtl/mbx_out_reg.sv
module mbx_out_reg #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= src;
  end

  a_r10_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
  a_r8_load_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(src)));
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
  import mbx_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int WORD_W = 18,
  parameter int BYTE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              b_sel,
  input  logic              b_en,
  input  logic              b_wr,
  input  logic              b_mbx,
  input  logic [1:0]        b_size,
  input  logic [DATA_W-1:0] b_data,
  input  logic              a_sel,
  input  logic              a_en,
  input  logic              a_rd,
  input  logic              a_mbx,
  output logic [DATA_W-1:0] a_data,
  output logic              mbx_full
);
  bus_size_e         size_e;
  logic [DATA_W-1:0] cap_word;
  logic [DATA_W-1:0] stored;
  logic              wr_req, rd_req, wr_acc;

  assign size_e = bus_size_e'(b_size);
  assign wr_req = b_sel && b_en && b_wr && b_mbx;
  assign rd_req = a_sel && a_en && a_rd && a_mbx;

  mbx_lane_capture #(.DATA_W(DATA_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) cap_i (
    .size (size_e),
    .din  (b_data),
    .cap  (cap_word)
  );

  mbx_store #(.DATA_W(DATA_W)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (wr_req),
    .rd_req  (rd_req),
    .wr_word (cap_word),
    .word_q  (stored),
    .full_q  (mbx_full),
    .wr_acc  (wr_acc)
  );

  mbx_out_reg #(.DATA_W(DATA_W)) out_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (rd_req),
    .src   (stored),
    .q     (a_data)
  );

  a_r3_long_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && (b_size == 2'b00 || b_size == 2'b11)) |=> (stored == $past(b_data)));
  a_r4_word_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && b_size == 2'b01) |=>
      (stored[DATA_W-1:WORD_W] == '0 && stored[WORD_W-1:0] == $past(b_data[WORD_W-1:0])));
  a_r5_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && b_size == 2'b10) |=>
      (stored[DATA_W-1:BYTE_W] == '0 && stored[BYTE_W-1:0] == $past(b_data[BYTE_W-1:0])));
  a_r2_unqualified_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_req && !mbx_full) |=> !mbx_full);
endmodule

// File: tb/mbx_bridge_tb_top.sv
module mbx_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 36;
  localparam int NVEC = 7;
  localparam logic [1:0]    VSIZE [NVEC] = '{2'b00, 2'b01, 2'b10, 2'b01, 2'b10, 2'b11, 2'b00};
  localparam logic [DW-1:0] VDATA [NVEC] = '{36'h9ABCD1234, 36'hFFFFFFFFF, 36'hFFFFFFFFF,
                                             36'h555555555, 36'h123456789, 36'hA5A5A5A5A,
                                             36'h000000000};
  localparam logic [DW-1:0] VEXP  [NVEC] = '{36'h9ABCD1234, 36'h00003FFFF, 36'h0000001FF,
                                             36'h000015555, 36'h000000189, 36'hA5A5A5A5A,
                                             36'h000000000};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic b_sel = 0, b_en = 0, b_wr = 0, b_mbx = 0;
  logic [1:0] b_size = 2'b00;
  logic [DW-1:0] b_data = '0;
  logic a_sel = 0, a_en = 0, a_rd = 0, a_mbx = 0;
  logic [DW-1:0] a_data;
  logic mbx_full;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .b_sel(b_sel), .b_en(b_en), .b_wr(b_wr), .b_mbx(b_mbx),
    .b_size(b_size), .b_data(b_data),
    .a_sel(a_sel), .a_en(a_en), .a_rd(a_rd), .a_mbx(a_mbx),
    .a_data(a_data), .mbx_full(mbx_full)
  );

  function automatic logic [DW-1:0] lane_mask(input logic [1:0] sz);
    case (sz)
      2'b01:   return {{(DW-18){1'b0}}, {18{1'b1}}};
      2'b10:   return {{(DW-9){1'b0}}, {9{1'b1}}};
      default: return {DW{1'b1}};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic b_op(input logic s, input logic e, input logic w, input logic m,
                      input logic [1:0] sz, input logic [DW-1:0] d);
    @(negedge clk);
    b_sel = s; b_en = e; b_wr = w; b_mbx = m; b_size = sz; b_data = d;
    @(negedge clk);
    b_sel = 0; b_en = 0; b_wr = 0; b_mbx = 0; b_data = '0;
  endtask

  task automatic a_op(input logic s, input logic e, input logic r, input logic m);
    @(negedge clk);
    a_sel = s; a_en = e; a_rd = r; a_mbx = m;
    @(negedge clk);
    a_sel = 0; a_en = 0; a_rd = 0; a_mbx = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset full", {35'd0, mbx_full}, '0);
    chk("R1 reset a_data", a_data, '0);
    rst_n = 1'b1;
    a_op(1, 1, 1, 1);
    chk("R1 read after reset", a_data, '0);

    for (int i = 0; i < NVEC; i++) begin
      b_op(1, 1, 1, 1, VSIZE[i], VDATA[i]);
      chk("R6 full after write", {35'd0, mbx_full}, 36'd1);
      a_op(1, 1, 1, 1);
      chk("R3 R4 R5 R8 read lanes", a_data & lane_mask(VSIZE[i]), VEXP[i]);
      chk("R8 full cleared", {35'd0, mbx_full}, '0);
    end

    b_op(1, 1, 1, 0, 2'b00, 36'h111111111);
    chk("R2 no mbx select", {35'd0, mbx_full}, '0);
    b_op(1, 1, 0, 1, 2'b00, 36'h222222222);
    chk("R2 read direction", {35'd0, mbx_full}, '0);
    b_op(0, 1, 1, 1, 2'b00, 36'h333333333);
    chk("R2 no chip select", {35'd0, mbx_full}, '0);
    b_op(1, 0, 1, 1, 2'b00, 36'h444444444);
    chk("R2 no enable", {35'd0, mbx_full}, '0);
    a_op(1, 1, 1, 1);
    chk("R2 stored unchanged", a_data, 36'h0);

    b_op(1, 1, 1, 1, 2'b00, 36'hCAFE0BEEF);
    b_op(1, 1, 1, 1, 2'b00, 36'h0DEAD0001);
    chk("R7 still full", {35'd0, mbx_full}, 36'd1);
    a_op(1, 1, 1, 1);
    chk("R7 first kept", a_data, 36'hCAFE0BEEF);
    a_op(1, 1, 1, 1);
    chk("R9 persists", a_data, 36'hCAFE0BEEF);
    chk("R9 flag stays clear", {35'd0, mbx_full}, '0);

    b_op(1, 1, 1, 1, 2'b00, 36'h876543210);
    a_op(1, 1, 0, 1);
    chk("R10 dir low a_data", a_data, 36'hCAFE0BEEF);
    a_op(0, 1, 1, 1);
    a_op(1, 0, 1, 1);
    a_op(1, 1, 1, 0);
    chk("R10 a_data held", a_data, 36'hCAFE0BEEF);
    chk("R10 full held", {35'd0, mbx_full}, 36'd1);
    a_op(1, 1, 1, 1);
    chk("R8 new word", a_data, 36'h876543210);

    b_op(1, 1, 1, 1, 2'b01, 36'hFFFFFFFFF);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset full", {35'd0, mbx_full}, '0);
    chk("R1 mid reset a_data", a_data, '0);
    rst_n = 1'b1;
    a_op(1, 1, 1, 1);
    chk("R1 mid reset stored", a_data, '0);

    summary();
  end
endmodule